// File: doc/BRIEF.md
# Clock-Crossing Timer Capture Unit

This block keeps a free-running up-counter in a timer clock domain and lets an agent in a separate bus clock domain read it safely. The bus side never samples the live counter, because its bits change with no fixed relation to the bus clock. The bus side asks for a capture instead. The request crosses into the timer domain as a toggle. The counter is latched there and the latch is acknowledged by a toggle in the opposite direction. A completion flag then rises on the bus side. Software polls the flag and then reads a value that stays fixed.

The timer clock is the fast root. A tick enable, derived from it by a selectable divider, gives the four fast rates and the slow rate. At a divided rate a capture waits for the next tick, so the latched value always lines up with a tick boundary. Because the capture has a real completion flag, software needs no guessed delay between the request and the read, whatever rate is selected.

Top module: `tsnap_top`

## Requirements
- R1: The counter is CNT_W bits wide. It is zero after reset, adds one on each tick and wraps from all-ones to zero.
- R2: When `cap_req` is 1 and no capture is in flight, `snap_valid` is 0 from the next `bus_clk` edge onward.
- R3: With `rate_sel` = 0 and the timer clock at half the bus clock frequency, `snap_valid` is back at 1 within 12 bus clocks of the request cycle.
- R4: A capture holds the counter value at the moment of the latch. At `rate_sel` = 0, two captures requested k timer clocks apart at the same clock phase differ by exactly k modulo 2^CNT_W.
- R5: `rate_sel` sets the tick divider d as follows: 0 gives d = 1, 1 gives d = 2, 2 gives d = 4, 3 gives d = 13, and 4 to 7 give d = DIV_SLOW (397). Two captures requested T timer clocks apart differ by a value between floor(T/d) and ceil(T/d).
- R6: At a divided rate the latch waits for the next tick. `snap_valid` returns within 2*(d+3)+6 bus clocks of the request.
- R7: A request made while a capture is in flight is ignored. `snap_valid` stays 0 until the first request completes, then rises once and stays high. The value comes from the first request.
- R8: `snap_val` is zero after reset. It loads the held capture only on a bus cycle with `rd_stb` = 1 while `snap_valid` is 1. In every other cycle, including `rd_stb` while `snap_valid` is 0, it stays unchanged.
- R9: `snap_valid` is 0 after reset. Once it is 1, it stays 1 until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-side clock |
| tmr_clk | input | 1 | Timer root clock |
| rst | input | 1 | Synchronous active-high reset in the bus clock domain, synchronized internally into the timer domain |
| rate_sel | input | 3 | Tick rate select, quasi-static |
| cap_req | input | 1 | Capture request strobe (bus domain) |
| rd_stb | input | 1 | Read strobe that moves the held capture to `snap_val` |
| snap_val | output | CNT_W | Last captured counter value that was read |
| snap_valid | output | 1 | Capture complete flag |

## Verification
At the undivided rate, requests are spaced by random even numbers of bus clocks, so every capture has the same timer-clock phase. The differences between captures must then equal the elapsed timer clocks exactly, which separates a correct latch point from an off-by-one or stale capture. One long directed gap and a reduced counter width force the counter to wrap. Each divided rate, including the slow rate, is then run with random gaps and checked against a floor/ceiling window and a latency bound; this shows whether the divider is decoded correctly and whether the capture waits for a tick. Directed sequences send a second request while one is in flight and pulse the read strobe while the flag is low. These confirm that both have no effect at the outputs.

// File: rtl/tsnap_pkg.sv
`timescale 1ns/1ps
package tsnap_pkg;
  localparam int RATE_W = 3;

  typedef enum logic [RATE_W-1:0] {
    RATE_FULL    = 3'd0,
    RATE_HALF    = 3'd1,
    RATE_QUARTER = 3'd2,
    RATE_MICRO   = 3'd3,
    RATE_SLOW    = 3'd4
  } rate_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tsnap_sync.sv
`timescale 1ns/1ps
module tsnap_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tsnap_tick_gen.sv
`timescale 1ns/1ps
module tsnap_tick_gen
  import tsnap_pkg::*;
#(
  parameter int DIV_HALF    = 2,
  parameter int DIV_QUARTER = 4,
  parameter int DIV_MICRO   = 13,
  parameter int DIV_SLOW    = 397
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate,
  output logic              tick_en
);
  localparam int DMAX  = max_of(max_of(DIV_HALF, DIV_QUARTER), max_of(DIV_MICRO, DIV_SLOW));
  localparam int PRE_W = $clog2(DMAX + 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last_q;

  always_comb begin
    case (rate)
      RATE_FULL:    last_q = '0;
      RATE_HALF:    last_q = PRE_W'(DIV_HALF - 1);
      RATE_QUARTER: last_q = PRE_W'(DIV_QUARTER - 1);
      RATE_MICRO:   last_q = PRE_W'(DIV_MICRO - 1);
      default:      last_q = PRE_W'(DIV_SLOW - 1);
    endcase
  end

  assign tick_en = (pre_q >= last_q);

  always_ff @(posedge clk) begin
    if (rst)          pre_q <= '0;
    else if (tick_en) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  // R5: prescaler never runs past the slowest divider
  assert_pre_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    pre_q < PRE_W'(DMAX));
endmodule

// File: rtl/tsnap_tmr_core.sv
`timescale 1ns/1ps
module tsnap_tmr_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             req_tgl_s,
  output logic [CNT_W-1:0] cap_q,
  output logic             ack_tgl
);
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             take;

  assign take = (req_tgl_s != seen_q) && tick_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      cap_q   <= '0;
      seen_q  <= 1'b0;
      ack_tgl <= 1'b0;
    end else begin
      if (tick_en) cnt_q <= cnt_q + 1'b1;
      if (take) begin
        cap_q   <= cnt_q;
        seen_q  <= req_tgl_s;
        ack_tgl <= ~ack_tgl;
      end
    end
  end

  // R1: one step per tick, wrapping modulo 2^CNT_W
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt_q));
  // R6: acknowledge only moves on a tick
  assert_ack_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(ack_tgl) |-> $past(tick_en));
  // R4: latched value is the counter at the latch edge
  assert_cap_matches_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ack_tgl) |-> cap_q == $past(cnt_q));
  // R8: capture register still while no acknowledge moves
  assert_cap_stable_R8: assert property (@(posedge clk) disable iff (rst)
    $stable(ack_tgl) |-> $stable(cap_q));
endmodule

// File: rtl/tsnap_bus_core.sv
`timescale 1ns/1ps
module tsnap_bus_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_req,
  input  logic             rd_stb,
  input  logic             ack_tgl_s,
  input  logic [CNT_W-1:0] cap_data,
  output logic             req_tgl,
  output logic [CNT_W-1:0] snap_val,
  output logic             snap_valid
);
  logic             busy_q;
  logic             ack_seen_q;
  logic [CNT_W-1:0] hold_q;
  logic             accept;
  logic             ack_new;

  assign accept  = cap_req && !busy_q;
  assign ack_new = (ack_tgl_s != ack_seen_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      ack_seen_q <= 1'b0;
      req_tgl    <= 1'b0;
      snap_valid <= 1'b0;
      hold_q     <= '0;
      snap_val   <= '0;
    end else begin
      if (accept) begin
        req_tgl    <= ~req_tgl;
        busy_q     <= 1'b1;
        snap_valid <= 1'b0;
      end
      if (ack_new) begin
        ack_seen_q <= ack_tgl_s;
        busy_q     <= 1'b0;
        snap_valid <= 1'b1;
        hold_q     <= cap_data;
      end
      if (rd_stb && snap_valid) snap_val <= hold_q;
    end
  end

  // R2: accepted request drops the flag on the next edge
  assert_req_clears_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !snap_valid);
  // R9: flag only falls on a request
  assert_valid_holds_R9: assert property (@(posedge clk) disable iff (rst)
    snap_valid && !cap_req |=> snap_valid);
  // R7: a request during a capture in flight leaves the request toggle alone
  assert_single_flight_R7: assert property (@(posedge clk) disable iff (rst)
    busy_q && cap_req |=> $stable(req_tgl));
  // R3: flag rises only as the end of a capture in flight
  assert_rise_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(snap_valid) |-> $past(busy_q));
  // R8: output register moves only on a read strobe
  assert_read_only_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(snap_val));
endmodule

// File: rtl/tsnap_top.sv
`timescale 1ns/1ps
module tsnap_top
  import tsnap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int DIV_HALF    = 2,
  parameter int DIV_QUARTER = 4,
  parameter int DIV_MICRO   = 13,
  parameter int DIV_SLOW    = 397,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              tmr_clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              cap_req,
  input  logic              rd_stb,
  output logic [CNT_W-1:0]  snap_val,
  output logic              snap_valid
);
  logic              tmr_rst;
  logic [RATE_W-1:0] rate_s;
  logic              tick_en;
  logic              req_tgl;
  logic              req_tgl_s;
  logic              ack_tgl;
  logic              ack_tgl_s;
  logic [CNT_W-1:0]  cap_q;

  tsnap_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(tmr_clk), .rst(1'b0), .d(rst), .q(tmr_rst));

  tsnap_sync #(.W(RATE_W), .STAGES(SYNC_STAGES)) u_rate_sync (
    .clk(tmr_clk), .rst(tmr_rst), .d(rate_sel), .q(rate_s));

  tsnap_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(tmr_clk), .rst(tmr_rst), .d(req_tgl), .q(req_tgl_s));

  tsnap_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst(rst), .d(ack_tgl), .q(ack_tgl_s));

  tsnap_tick_gen #(
    .DIV_HALF(DIV_HALF), .DIV_QUARTER(DIV_QUARTER),
    .DIV_MICRO(DIV_MICRO), .DIV_SLOW(DIV_SLOW)
  ) u_tick (
    .clk(tmr_clk), .rst(tmr_rst), .rate(rate_s), .tick_en(tick_en));

  tsnap_tmr_core #(.CNT_W(CNT_W)) u_tmr (
    .clk(tmr_clk), .rst(tmr_rst), .tick_en(tick_en),
    .req_tgl_s(req_tgl_s), .cap_q(cap_q), .ack_tgl(ack_tgl));

  tsnap_bus_core #(.CNT_W(CNT_W)) u_bus (
    .clk(bus_clk), .rst(rst), .cap_req(cap_req), .rd_stb(rd_stb),
    .ack_tgl_s(ack_tgl_s), .cap_data(cap_q), .req_tgl(req_tgl),
    .snap_val(snap_val), .snap_valid(snap_valid));
endmodule

// File: tb/tb_tsnap_top.sv
`timescale 1ns/1ps
module tb_tsnap_top;
  localparam int CW = 12;
  localparam int DS = 397;
  localparam longint MOD = 64'd1 << CW;

  logic          bus_clk = 1'b0;
  logic          tmr_clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    rate_sel = 3'd0;
  logic          cap_req = 1'b0;
  logic          rd_stb = 1'b0;
  logic [CW-1:0] snap_val;
  logic          snap_valid;

  int     nvec = 0;
  int     nbad = 0;
  longint cyc = 0;
  logic [CW-1:0] last_read = '0;

  always #2.5 bus_clk = ~bus_clk;
  always #5   tmr_clk = ~tmr_clk;
  always @(posedge bus_clk) cyc <= cyc + 1;

  tsnap_top #(.CNT_W(CW), .DIV_SLOW(DS)) dut (
    .bus_clk(bus_clk), .tmr_clk(tmr_clk), .rst(rst), .rate_sel(rate_sel),
    .cap_req(cap_req), .rd_stb(rd_stb), .snap_val(snap_val), .snap_valid(snap_valid));

  function automatic int div_of(input int r);
    case (r)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 13;
      default: return DS;
    endcase
  endfunction

  function automatic int lat_limit(input int r);
    if (r == 0) return 12;
    return 2 * (div_of(r) + 3) + 6;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic chk_rng(input string rq, input longint act, input longint lo, input longint hi);
    nvec++;
    if (act < lo || act > hi) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", rq, act, lo, hi);
    end
  endtask

  task automatic wait_bus(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic align_even();
    if (cyc[0]) wait_bus(1);
  endtask

  // Request, check the flag drop, wait for completion, then read.
  task automatic capture(input int rate, output logic [CW-1:0] v, output longint rc);
    int lat;
    cap_req = 1'b1;
    rc = cyc;
    @(negedge bus_clk);
    cap_req = 1'b0;
    chk(snap_valid == 1'b0, "R2 flag drop", snap_valid, 0);
    lat = 1;
    while (!snap_valid && lat <= lat_limit(rate)) begin
      @(negedge bus_clk);
      lat++;
    end
    if (rate == 0) chk(snap_valid == 1'b1, "R3 latency", lat, lat_limit(rate));
    else           chk(snap_valid == 1'b1, "R6 latency", lat, lat_limit(rate));
    chk(snap_val == last_read, "R8 no read yet", snap_val, last_read);
    rd_stb = 1'b1;
    @(negedge bus_clk);
    rd_stb = 1'b0;
    v = snap_val;
    last_read = v;
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge bus_clk);
    nbad++;
    nvec++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin : main
    logic [CW-1:0] v, pv;
    longint rc, prc, rel, d;
    bit wrap_seen;
    bit dropped;
    void'($urandom(32'd20240611));
    wrap_seen = 1'b0;

    wait_bus(10);
    chk(snap_valid == 1'b0, "R9 reset flag", snap_valid, 0);
    chk(snap_val == '0, "R8 reset value", snap_val, 0);
    rst = 1'b0;
    rel = cyc;
    wait_bus(6);

    // R1: counter starts from zero
    align_even();
    capture(0, pv, prc);
    chk(longint'(pv) <= (prc - rel) / 2 + 2, "R1 start from zero", pv, (prc - rel) / 2 + 2);

    // R4: exact deltas at the undivided rate
    for (int i = 0; i < 30; i++) begin
      wait_bus($urandom_range(20, 600));
      align_even();
      capture(0, v, rc);
      d = (longint'(v) - longint'(pv) + MOD) % MOD;
      chk(d == ((rc - prc) / 2) % MOD, "R4 exact delta", d, ((rc - prc) / 2) % MOD);
      if (v < pv) wrap_seen = 1'b1;
      pv = v; prc = rc;
    end

    // R1: directed wrap, 4100 ticks on a 4096 modulus
    wait_bus(8200 - 12);
    align_even();
    capture(0, v, rc);
    d = (longint'(v) - longint'(pv) + MOD) % MOD;
    chk(d == ((rc - prc) / 2) % MOD, "R1 wrap delta", d, ((rc - prc) / 2) % MOD);
    if (v < pv) wrap_seen = 1'b1;
    chk(wrap_seen, "R1 wrap seen", wrap_seen, 1);
    pv = v; prc = rc;

    // R7 / R8: second request in flight, read while flag low
    wait_bus(50);
    align_even();
    cap_req = 1'b1;
    rc = cyc;
    @(negedge bus_clk);
    cap_req = 1'b0;
    wait_bus(2);
    cap_req = 1'b1;
    @(negedge bus_clk);
    cap_req = 1'b0;
    rd_stb = 1'b1;
    @(negedge bus_clk);
    rd_stb = 1'b0;
    chk(snap_valid == 1'b0, "R7 still pending", snap_valid, 0);
    chk(snap_val == last_read, "R8 read while low", snap_val, last_read);
    for (int k = 0; k < 20 && !snap_valid; k++) @(negedge bus_clk);
    chk(snap_valid == 1'b1, "R7 completes", snap_valid, 1);
    dropped = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge bus_clk);
      if (!snap_valid) dropped = 1'b1;
    end
    chk(!dropped, "R7 no second capture", dropped, 0);
    chk(snap_val == last_read, "R8 hold without strobe", snap_val, last_read);
    rd_stb = 1'b1;
    @(negedge bus_clk);
    rd_stb = 1'b0;
    v = snap_val;
    last_read = v;
    d = (longint'(v) - longint'(pv) + MOD) % MOD;
    chk(d == ((rc - prc) / 2) % MOD, "R7 first request value", d, ((rc - prc) / 2) % MOD);
    chk(snap_valid == 1'b1, "R9 flag held", snap_valid, 1);

    // R5 / R6: divided rates
    for (int r = 1; r <= 5; r++) begin
      int n;
      rate_sel = 3'(r);
      wait_bus(2 * div_of(r) + 40);
      align_even();
      capture(r, pv, prc);
      n = (r >= 4) ? 3 : 5;
      for (int i = 0; i < n; i++) begin
        longint t, lo, hi;
        wait_bus((r >= 4) ? $urandom_range(800, 2000) : $urandom_range(30, 400));
        align_even();
        capture(r, v, rc);
        t  = (rc - prc) / 2;
        lo = t / div_of(r);
        hi = (t + div_of(r) - 1) / div_of(r);
        d  = (longint'(v) - longint'(pv) + MOD) % MOD;
        chk_rng("R5 tick rate", d, lo, hi);
        pv = v; prc = rc;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule